// File: doc/BRIEF.md
# Macro Execute Unit with Register Bank

This block is the execute stage of a small macro sequencer. Each cycle it can accept one operation that names two source registers, a destination register, an opcode, an ALU function, an 18-bit immediate and three bitfield controls: a source position, a destination position and a width. It reads the two sources from a bank of seven 32-bit storage registers plus a constant-zero register. It computes a result, returns it on a registered output and writes it back to the destination in the same clock edge.

Two operation families are available. The register ALU family covers add and subtract, both with a carry or borrow flag that can be chained into the next operation, and the logic functions XOR, OR, AND, AND-NOT and NAND. The second family covers add-immediate and three bitfield operations: merge, and extract-and-shift in two variants that take one bit position from a register. The issuing sequencer handles memory reads and branch decisions.

Top module: `macro_exec`

## Requirements
- R1: After reset `res_valid` is 0, `carry_out` is 0, and every register 1 to 7 reads as 0.
- R2: Register index 0 always reads as 0. A write aimed at index 0 is discarded, although `res_data` still shows the computed value.
- R3: An operation sampled with `issue_valid` high on a rising edge has its `res_data`, `carry_out` and register write-back take effect on that same edge. `res_valid` is high for exactly the cycles that follow an issue cycle. An operation issued in the next cycle reads the new register value.
- R4: Opcode 0 with ALU function 0 computes x+y, and function 1 computes x+y+carry. Both wrap to 32 bits, and both set carry to (result < x, unsigned).
- R5: Opcode 0 with ALU function 2 computes x-y, and function 3 computes x-y-carry. Both wrap to 32 bits, and both set carry to (result > x, unsigned).
- R6: Opcode 0 with ALU functions 4 to 8 computes, in that order, x^y, x|y, x&y, x&~y and ~(x&y). These functions, and every opcode other than 0, leave carry unchanged.
- R7: Opcode 1 computes x plus the 18-bit immediate sign-extended to 32 bits.
- R8: Opcode 2 (merge) takes `bf_size` bits of y starting at bit `bf_src` and places them into x at bit `bf_dst`. All other bits of x are kept. The result is truncated to 32 bits.
- R9: Opcode 3 takes `bf_size` bits of y starting at bit position x (the register value) and places them at bit `bf_dst` of a zero word.
- R10: Opcode 4 takes `bf_size` bits of y starting at bit `bf_src` and places them at bit position x (the register value) of a zero word.
- R11: For opcodes 3 and 4 the result is 0 when the position taken from x exceeds 31. A `bf_size` of 0 selects no bits, so merge then returns x unchanged.
- R12: Opcodes 5 to 7 return 0 and write no register. ALU functions 9 to 15 return 0, write 0 to the destination and leave carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Opcode: 0 register ALU, 1 add-immediate, 2 merge, 3 extract with source position from x, 4 extract with destination position from x |
| alu_fn | input | 4 | ALU function for opcode 0 (encoding in R4 to R6) |
| src_x | input | 3 | Index of source register x |
| src_y | input | 3 | Index of source register y |
| dst | input | 3 | Destination register index (0 discards) |
| imm | input | 18 | Signed immediate for add-immediate |
| bf_src | input | 5 | Bitfield source bit position |
| bf_dst | input | 5 | Bitfield destination bit position |
| bf_size | input | 5 | Bitfield width in bits |
| res_valid | output | 1 | Result of the previous cycle's issue is present |
| res_data | output | 32 | Registered result |
| carry_out | output | 1 | Current carry flag |

## Verification
Every result, carry update and register write is due on the first rising edge after the issue cycle. The bench therefore samples the outputs on the falling edge that follows, half a period after the design updates them. The driver issues operations on consecutive falling edges so that dependent back-to-back operations are exercised. Each issue pushes one expected result and carry into a queue. Each cycle with `res_valid` high pops exactly one entry, and the queue must be empty once issues stop, so any extra or missing result cycle is reported. Register contents and discarded writes are observed by issuing an OR with register 0 after the stimulus.

// File: rtl/macro_pkg.sv
package macro_pkg;

  typedef enum logic [2:0] {
    OP_ALU      = 3'd0,
    OP_ADDI     = 3'd1,
    OP_MERGE    = 3'd2,
    OP_BFE_SRCX = 3'd3,
    OP_BFE_DSTX = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    FN_ADD  = 4'd0,
    FN_ADDC = 4'd1,
    FN_SUB  = 4'd2,
    FN_SUBB = 4'd3,
    FN_XOR  = 4'd4,
    FN_OR   = 4'd5,
    FN_AND  = 4'd6,
    FN_ANDN = 4'd7,
    FN_NAND = 4'd8
  } alu_fn_e;

  typedef enum logic [1:0] {
    BF_MERGE     = 2'd0,
    BF_FROM_SRCX = 2'd1,
    BF_TO_DSTX   = 2'd2
  } bf_mode_e;

endpackage

// File: rtl/macro_regfile.sv
module macro_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [IDX_W-1:0]  ry_idx,
  output logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] ry_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] bank [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) bank[i] <= '0;
    end else if (wr_en && (wr_idx != '0)) begin
      bank[wr_idx] <= wr_data;
    end
  end

  assign rx_data = (rx_idx == '0) ? '0 : bank[rx_idx];
  assign ry_data = (ry_idx == '0) ? '0 : bank[ry_idx];

endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import macro_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic [3:0]        fn,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry_new,
  output logic              carry_we
);

  logic [DATA_W-1:0] cin_ext;
  assign cin_ext = {{(DATA_W-1){1'b0}}, carry_in};

  always_comb begin
    res       = '0;
    carry_new = carry_in;
    carry_we  = 1'b0;
    case (alu_fn_e'(fn))
      FN_ADD: begin
        res       = x + y;
        carry_new = (res < x);
        carry_we  = 1'b1;
      end
      FN_ADDC: begin
        res       = x + y + cin_ext;
        carry_new = (res < x);
        carry_we  = 1'b1;
      end
      FN_SUB: begin
        res       = x - y;
        carry_new = (res > x);
        carry_we  = 1'b1;
      end
      FN_SUBB: begin
        res       = x - y - cin_ext;
        carry_new = (res > x);
        carry_we  = 1'b1;
      end
      FN_XOR:  res = x ^ y;
      FN_OR:   res = x | y;
      FN_AND:  res = x & y;
      FN_ANDN: res = x & ~y;
      FN_NAND: res = ~(x & y);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/macro_bitfield.sv
module macro_bitfield
  import macro_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic [1:0]        mode,
  input  logic [POS_W-1:0]  f_src,
  input  logic [POS_W-1:0]  f_dst,
  input  logic [POS_W-1:0]  f_size,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] src_pos, dst_pos;
  logic              out_of_range;
  logic [DATA_W-1:0] mask, field, placed, hole;

  always_comb begin
    src_pos = {{(DATA_W-POS_W){1'b0}}, f_src};
    dst_pos = {{(DATA_W-POS_W){1'b0}}, f_dst};
    case (bf_mode_e'(mode))
      BF_FROM_SRCX: src_pos = x;
      BF_TO_DSTX:   dst_pos = x;
      default: ;
    endcase
  end

  assign out_of_range = (|src_pos[DATA_W-1:POS_W]) | (|dst_pos[DATA_W-1:POS_W]);
  assign mask   = ({{(DATA_W-1){1'b0}}, 1'b1} << f_size) - 1'b1;
  assign field  = (y >> src_pos[POS_W-1:0]) & mask;
  assign placed = field << dst_pos[POS_W-1:0];
  assign hole   = ~(mask << dst_pos[POS_W-1:0]);

  always_comb begin
    if (bf_mode_e'(mode) == BF_MERGE) res = (x & hole) | placed;
    else if (out_of_range)            res = '0;
    else                              res = placed;
  end

endmodule

// File: rtl/macro_exec.sv
module macro_exec
  import macro_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  parameter int IMM_W  = 18,
  localparam int IDX_W = $clog2(NREGS),
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [2:0]        op,
  input  logic [3:0]        alu_fn,
  input  logic [IDX_W-1:0]  src_x,
  input  logic [IDX_W-1:0]  src_y,
  input  logic [IDX_W-1:0]  dst,
  input  logic [IMM_W-1:0]  imm,
  input  logic [POS_W-1:0]  bf_src,
  input  logic [POS_W-1:0]  bf_dst,
  input  logic [POS_W-1:0]  bf_size,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              carry_out
);

  op_e               op_q;
  logic [DATA_W-1:0] x_data, y_data, imm_ext;
  logic [DATA_W-1:0] alu_res, bf_res, result;
  logic              alu_carry, alu_cwe, op_known;
  logic [1:0]        bf_mode;

  assign op_q    = op_e'(op);
  assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  macro_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst(rst),
    .rx_idx(src_x), .ry_idx(src_y),
    .rx_data(x_data), .ry_data(y_data),
    .wr_en(issue_valid && op_known), .wr_idx(dst), .wr_data(result)
  );

  macro_alu #(.DATA_W(DATA_W)) u_alu (
    .x(x_data), .y(y_data), .fn(alu_fn), .carry_in(carry_out),
    .res(alu_res), .carry_new(alu_carry), .carry_we(alu_cwe)
  );

  always_comb begin
    case (op_q)
      OP_BFE_SRCX: bf_mode = BF_FROM_SRCX;
      OP_BFE_DSTX: bf_mode = BF_TO_DSTX;
      default:     bf_mode = BF_MERGE;
    endcase
  end

  macro_bitfield #(.DATA_W(DATA_W)) u_bf (
    .x(x_data), .y(y_data), .mode(bf_mode),
    .f_src(bf_src), .f_dst(bf_dst), .f_size(bf_size),
    .res(bf_res)
  );

  always_comb begin
    op_known = 1'b1;
    case (op_q)
      OP_ALU:                          result = alu_res;
      OP_ADDI:                         result = x_data + imm_ext;
      OP_MERGE, OP_BFE_SRCX, OP_BFE_DSTX: result = bf_res;
      default: begin
        result   = '0;
        op_known = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      carry_out <= 1'b0;
    end else begin
      res_valid <= issue_valid;
      if (issue_valid) res_data <= result;
      if (issue_valid && (op_q == OP_ALU) && alu_cwe) carry_out <= alu_carry;
    end
  end

  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> res_valid); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !res_valid); // R3
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && op == 3'd0 && (alu_fn == 4'd0 || alu_fn == 4'd1))
    |=> (carry_out == (res_data < $past(x_data)))); // R4
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && op == 3'd0 && (alu_fn == 4'd2 || alu_fn == 4'd3))
    |=> (carry_out == (res_data > $past(x_data)))); // R5
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (op != 3'd0 || alu_fn > 4'd3)) |=> $stable(carry_out)); // R6
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (op == 3'd3 || op == 3'd4) && x_data > 31)
    |=> (res_data == '0)); // R11

endmodule

// File: tb/sim_macro_exec.sv
`timescale 1ns/1ps
module sim_macro_exec;

  typedef struct {
    logic [31:0] d;
    logic        c;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  alu_fn = '0;
  logic [2:0]  src_x = '0, src_y = '0, dst = '0;
  logic [17:0] imm = '0;
  logic [4:0]  bf_src = '0, bf_dst = '0, bf_size = '0;
  logic        res_valid, carry_out;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  exp_t sb[$];
  logic [31:0] mreg [8];
  logic        mcarry = 1'b0;

  always #2 clk = ~clk;

  macro_exec u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .op(op), .alu_fn(alu_fn),
    .src_x(src_x), .src_y(src_y), .dst(dst), .imm(imm),
    .bf_src(bf_src), .bf_dst(bf_dst), .bf_size(bf_size),
    .res_valid(res_valid), .res_data(res_data), .carry_out(carry_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fmask(input int sz);
    return (sz == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - sz));
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] y, input logic [31:0] sp,
                                          input logic [31:0] dp, input int sz);
    if (sp > 31 || dp > 31) return 32'h0;
    return ((y >> sp) & fmask(sz)) << dp;
  endfunction

  task automatic issue(input int o, input int f, input int d, input int sx, input int sy,
                       input int im, input int fs, input int fd, input int fz, input string tag);
    logic [31:0] x, y, r;
    logic        c;
    logic [31:0] m;
    exp_t e;
    x = mreg[sx];
    y = mreg[sy];
    c = mcarry;
    r = 32'h0;
    m = fmask(fz);
    case (o)
      0: case (f)
        0: begin r = x + y; c = r < x; end
        1: begin r = x + y + {31'h0, mcarry}; c = r < x; end
        2: begin r = x - y; c = r > x; end
        3: begin r = x - y - {31'h0, mcarry}; c = r > x; end
        4: r = x ^ y;
        5: r = x | y;
        6: r = x & y;
        7: r = x & ~y;
        8: r = ~(x & y);
        default: r = 32'h0;
      endcase
      1: r = x + {{14{im[17]}}, im[17:0]};
      2: r = (x & ~(m << fd)) | (((y >> fs) & m) << fd);
      3: r = extract(y, x, fd, fz);
      4: r = extract(y, fs, x, fz);
      default: r = 32'h0;
    endcase
    if (o <= 4 && d != 0) mreg[d] = r;
    mcarry = c;
    @(negedge clk);
    issue_valid = 1'b1;
    op = o[2:0]; alu_fn = f[3:0]; dst = d[2:0]; src_x = sx[2:0]; src_y = sy[2:0];
    imm = im[17:0]; bf_src = fs[4:0]; bf_dst = fd[4:0]; bf_size = fz[4:0];
    e.d = r; e.c = c; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3 unexpected result", res_data, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(res_data === e.d, {e.tag, " data"}, res_data, e.d);
        chk(carry_out === e.c, {e.tag, " carry"}, {31'h0, carry_out}, {31'h0, e.c});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid === 1'b0, "R1 valid after reset", {31'h0, res_valid}, 32'h0);
    chk(carry_out === 1'b0, "R1 carry after reset", {31'h0, carry_out}, 32'h0);
    for (int i = 1; i < 8; i++) issue(0, 5, 0, i, 0, 0, 0, 0, 0, "R1 reg reset");
    // add-immediate, sign extension
    issue(1, 0, 1, 0, 0, 5, 0, 0, 0, "R7 addi pos");
    issue(1, 0, 2, 0, 0, 18'h3FFFD, 0, 0, 0, "R7 addi neg");
    issue(1, 0, 3, 0, 0, 18'h1FFFF, 0, 0, 0, "R7 addi max");
    issue(1, 0, 7, 0, 0, 18'h3FFFF, 0, 0, 0, "R7 addi all ones");
    // zero register
    issue(1, 0, 0, 0, 0, 99, 0, 0, 0, "R2 write r0");
    issue(0, 5, 0, 0, 0, 0, 0, 0, 0, "R2 read r0");
    // back-to-back dependency
    issue(1, 0, 5, 0, 0, 10, 0, 0, 0, "R3 set r5");
    issue(1, 0, 5, 5, 0, 1, 0, 0, 0, "R3 forward r5");
    // add with carry chain
    issue(0, 0, 6, 2, 1, 0, 0, 0, 0, "R4 add wrap");
    issue(0, 1, 6, 1, 1, 0, 0, 0, 0, "R4 addc");
    issue(0, 0, 6, 2, 1, 0, 0, 0, 0, "R4 add carry set");
    issue(0, 1, 6, 1, 7, 0, 0, 0, 0, "R4 addc equal x");
    // subtract with borrow
    issue(0, 2, 6, 1, 5, 0, 0, 0, 0, "R5 sub borrow");
    issue(0, 3, 6, 5, 1, 0, 0, 0, 0, "R5 subb");
    issue(0, 3, 6, 0, 0, 0, 0, 0, 0, "R5 subb zero");
    issue(0, 2, 6, 1, 5, 0, 0, 0, 0, "R6 carry set");
    // logic ops keep carry
    issue(0, 4, 6, 2, 5, 0, 0, 0, 0, "R6 xor");
    issue(0, 5, 6, 2, 5, 0, 0, 0, 0, "R6 or");
    issue(0, 6, 6, 2, 5, 0, 0, 0, 0, "R6 and");
    issue(0, 7, 6, 2, 5, 0, 0, 0, 0, "R6 andnot");
    issue(0, 8, 6, 2, 5, 0, 0, 0, 0, "R6 nand");
    // bitfield ops
    issue(2, 0, 6, 2, 5, 0, 0, 8, 4, "R8 merge");
    issue(2, 0, 6, 7, 5, 0, 1, 28, 8, "R8 merge truncated");
    issue(2, 0, 6, 2, 5, 0, 0, 8, 0, "R11 merge size0");
    issue(3, 0, 6, 1, 2, 0, 0, 4, 3, "R9 extract srcx");
    issue(3, 0, 6, 7, 2, 0, 0, 4, 3, "R11 srcx oob");
    issue(4, 0, 6, 1, 5, 0, 2, 0, 4, "R10 extract dstx");
    issue(1, 0, 3, 0, 0, 32, 0, 0, 0, "R11 set 32");
    issue(4, 0, 6, 3, 7, 0, 0, 0, 1, "R11 dstx oob");
    issue(1, 0, 4, 0, 0, 31, 0, 0, 0, "R10 set 31");
    issue(4, 0, 6, 4, 7, 0, 0, 0, 1, "R10 dstx 31");
    // undefined codes
    issue(0, 8, 6, 0, 0, 0, 0, 0, 0, "R12 nand zero");
    issue(5, 0, 1, 2, 5, 0, 0, 0, 0, "R12 undefined op");
    issue(0, 12, 2, 2, 5, 0, 0, 0, 0, "R12 undefined fn");
    issue(0, 5, 0, 1, 0, 0, 0, 0, 0, "R12 r1 kept");
    issue(0, 5, 0, 2, 0, 0, 0, 0, 0, "R12 r2 cleared");
    for (int i = 1; i < 8; i++) issue(0, 5, 0, i, 0, 0, 0, 0, 0, "R2 final regs");
    @(negedge clk);
    issue_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R3 queue drained", sb.size(), 32'h0);
    chk(res_valid === 1'b0, "R3 valid drops", {31'h0, res_valid}, 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule